// File: doc/BRIEF.md
# I2C Slave Bus Framing Engine

This block is the bus-facing front end of a slave-only two-wire serial port. It oversamples the SCL and SDA lines with a fast system clock and cleans them up. It recognises start, repeated-start and stop conditions, shifts in 8-bit words and decides whether the first word after a start selects this device. It acknowledges that word and every written byte by pulling SDA low through an open-drain output enable. It also shifts read data out onto the bus. Received bytes and framing events go to a register file as single-cycle pulses. The register file supplies read bytes on request.

The device address has seven bits. Its upper five bits are a parameter and its lower two bits come from a four-state strap input, so four copies of the block can share one bus. A stop is honoured at any point of a transfer, including in the middle of a byte, and it returns the block to idle. The one exception is a stop that arrives within the same SCL-high pulse as a start: that sequence is illegal, so the stop is discarded. A repeated start behaves exactly like a start. The system clock must run at least 16 times faster than SCL, for bus rates up to 400 kHz.

Top module: `i2c_target_framer`

## Requirements
- R1: A falling SDA while SCL is high (both after filtering) produces one `start_o` pulse. A rising SDA while SCL is high produces one `stop_o` pulse. The only exception is the case in R8.
- R2: After reset `sda_oe_o`, `start_o`, `stop_o`, `sel_o`, `wr_valid_o` and `rd_req_o` are all 0, and SDA is released.
- R3: The first byte after a start is taken MSB first, sampled on rising SCL. Bits 7..1 are the address and bit 0 is the direction (1 = read). The own address is `{ADDR_HI, strap_i}`. On a match `sel_o` pulses and SDA is held low for the whole ninth clock. On a mismatch SDA stays released until the next start.
- R4: In a write, each data byte is taken MSB first. At the falling SCL edge that ends its eighth bit, `wr_valid_o` pulses with the byte on `wr_data_o`, and SDA is held low through the ninth clock.
- R5: In a read, `rd_req_o` pulses and `rd_data_i` is captured at the falling SCL edge that ends the address acknowledge or a master acknowledge. The byte is driven MSB first, one bit per clock, with `sda_oe_o` equal to the inverse of the bit.
- R6: If SDA is high at the rising SCL edge of the ninth clock of a read byte, that is a master NACK. It ends the read: no further `rd_req_o` and SDA stays released until the next start or stop.
- R7: An accepted stop at any bit position aborts the transfer, releases SDA, gives no `wr_valid_o` for a partial byte and returns the block to idle.
- R8: A stop inside the same SCL-high pulse as a start is ignored: no `stop_o` pulse, and address reception continues.
- R9: A repeated start, sent without a stop, restarts address reception and gives a new `start_o`.
- R10: `sda_oe_o` changes only right after a filtered falling SCL edge, a start or a stop.
- R11: Each line is synchronised by two flops and then passes a 3-sample filter. A pulse shorter than three system clocks on either line has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus) |
| strap_i | input | 2 | Four-state address strap, lower two address bits |
| rd_data_i | input | 8 | Read byte from the register file, taken when `rd_req_o` pulses |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| start_o | output | 1 | Pulse: start or repeated start seen |
| stop_o | output | 1 | Pulse: accepted stop seen |
| sel_o | output | 1 | Pulse: address matched, acknowledge being driven |
| wr_valid_o | output | 1 | Pulse: a written byte is on `wr_data_o` |
| wr_data_o | output | 8 | Last received data byte |
| rd_req_o | output | 1 | Pulse: `rd_data_i` was captured for transmission |

## Verification
Checked on every cycle by the assertions:
- SDA moves only after a falling SCL edge or a bus condition.
- SDA is released whenever a start or stop is reported.
- An address match or a written byte always comes with an acknowledge that is being driven.

Only the bench scenarios can show the rest: the bytes received and sent, the decoding of the address strap, the abort on a stop in the middle of a byte, the ignored stop after a start in one high pulse, the end of a read on NACK, and the rejection of short glitches.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_WR,
        PH_WR_ACK,
        PH_RD,
        PH_RD_ACK,
        PH_IGNORE
    } phase_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        phase_e     phase;
        logic [3:0] cnt;
        logic [7:0] shreg;
        logic       rw;
        logic       nack;
        logic       oe;
        logic       start_p;
        logic       stop_p;
        logic       sel_p;
        logic       wr_p;
        logic       rd_p;
    } fsm_t;

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int SL = SYNC_STAGES - 1;
    localparam int FL = FILT_LEN - 1;

    logic [SL:0] sync_d, sync_q;
    logic [FL:0] hist_d, hist_q;
    logic        filt_d, filt_q;

    always_comb begin
        sync_d = {sync_q[SL-1:0], line_i};
        hist_d = {hist_q[FL-1:0], sync_q[SL]};
        if (&hist_q)
            filt_d = 1'b1;
        else if (~|hist_q)
            filt_d = 1'b0;
        else
            filt_d = filt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            filt_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            hist_q <= hist_d;
            filt_q <= filt_d;
        end
    end

    assign line_o = filt_q;
endmodule

// File: rtl/i2cs_cond_detect.sv
module i2cs_cond_detect
    import i2cs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t evt_o
);
    logic scl_p_d, scl_p_q;
    logic sda_p_d, sda_p_q;
    logic armed_d, armed_q;
    logic raw_start, raw_stop;

    always_comb begin
        raw_start = scl_f & scl_p_q & sda_p_q & ~sda_f;
        raw_stop  = scl_f & scl_p_q & ~sda_p_q & sda_f;

        evt_o.scl_rise = scl_f & ~scl_p_q;
        evt_o.scl_fall = ~scl_f & scl_p_q;
        evt_o.start    = raw_start;
        evt_o.stop     = raw_stop & ~armed_q;

        scl_p_d = scl_f;
        sda_p_d = sda_f;
        if (raw_start)
            armed_d = 1'b1;
        else if (evt_o.scl_fall)
            armed_d = 1'b0;
        else
            armed_d = armed_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
            armed_q <= 1'b0;
        end else begin
            scl_p_q <= scl_p_d;
            sda_p_q <= sda_p_d;
            armed_q <= armed_d;
        end
    end
endmodule

// File: rtl/i2cs_frame_fsm.sv
module i2cs_frame_fsm
    import i2cs_pkg::*;
#(
    parameter int ADDR_HI_W = 5,
    parameter logic [ADDR_HI_W-1:0] ADDR_HI = 5'b10100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  bus_evt_t   evt_i,
    input  logic       sda_f,
    input  logic [1:0] strap_i,
    input  logic [7:0] rd_data_i,
    output logic       sda_oe_o,
    output logic       start_o,
    output logic       stop_o,
    output logic       sel_o,
    output logic       wr_valid_o,
    output logic [7:0] wr_data_o,
    output logic       rd_req_o
);
    localparam int         ADDR_W    = ADDR_HI_W + 2;
    localparam logic [3:0] BYTE_BITS = 4'd8;
    localparam logic [3:0] LAST_OUT  = 4'd7;

    fsm_t d, q;
    logic [ADDR_W-1:0] own_addr;

    assign own_addr = {ADDR_HI, strap_i};

    always_comb begin
        d         = q;
        d.start_p = 1'b0;
        d.stop_p  = 1'b0;
        d.sel_p   = 1'b0;
        d.wr_p    = 1'b0;
        d.rd_p    = 1'b0;

        if (evt_i.stop) begin
            d.phase  = PH_IDLE;
            d.oe     = 1'b0;
            d.stop_p = 1'b1;
        end else if (evt_i.start) begin
            d.phase   = PH_ADDR;
            d.cnt     = '0;
            d.oe      = 1'b0;
            d.start_p = 1'b1;
        end else begin
            unique case (q.phase)
                PH_ADDR: begin
                    if (evt_i.scl_rise && q.cnt < BYTE_BITS) begin
                        d.shreg = {q.shreg[6:0], sda_f};
                        d.cnt   = q.cnt + 4'd1;
                    end else if (evt_i.scl_fall && q.cnt == BYTE_BITS) begin
                        if (q.shreg[7:1] == own_addr) begin
                            d.phase = PH_ADDR_ACK;
                            d.rw    = q.shreg[0];
                            d.oe    = 1'b1;
                            d.sel_p = 1'b1;
                        end else begin
                            d.phase = PH_IGNORE;
                            d.oe    = 1'b0;
                        end
                    end
                end
                PH_ADDR_ACK: begin
                    if (evt_i.scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.phase = PH_RD;
                            d.shreg = rd_data_i;
                            d.oe    = ~rd_data_i[7];
                            d.rd_p  = 1'b1;
                        end else begin
                            d.phase = PH_WR;
                            d.oe    = 1'b0;
                        end
                    end
                end
                PH_WR: begin
                    if (evt_i.scl_rise && q.cnt < BYTE_BITS) begin
                        d.shreg = {q.shreg[6:0], sda_f};
                        d.cnt   = q.cnt + 4'd1;
                    end else if (evt_i.scl_fall && q.cnt == BYTE_BITS) begin
                        d.phase = PH_WR_ACK;
                        d.oe    = 1'b1;
                        d.wr_p  = 1'b1;
                    end
                end
                PH_WR_ACK: begin
                    if (evt_i.scl_fall) begin
                        d.phase = PH_WR;
                        d.cnt   = '0;
                        d.oe    = 1'b0;
                    end
                end
                PH_RD: begin
                    if (evt_i.scl_fall) begin
                        if (q.cnt == LAST_OUT) begin
                            d.phase = PH_RD_ACK;
                            d.oe    = 1'b0;
                        end else begin
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.oe    = ~q.shreg[6];
                            d.cnt   = q.cnt + 4'd1;
                        end
                    end
                end
                PH_RD_ACK: begin
                    if (evt_i.scl_rise) begin
                        d.nack = sda_f;
                    end else if (evt_i.scl_fall) begin
                        d.cnt = '0;
                        if (q.nack) begin
                            d.phase = PH_IGNORE;
                            d.oe    = 1'b0;
                        end else begin
                            d.phase = PH_RD;
                            d.shreg = rd_data_i;
                            d.oe    = ~rd_data_i[7];
                            d.rd_p  = 1'b1;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign sda_oe_o   = q.oe;
    assign start_o    = q.start_p;
    assign stop_o     = q.stop_p;
    assign sel_o      = q.sel_p;
    assign wr_valid_o = q.wr_p;
    assign wr_data_o  = q.shreg;
    assign rd_req_o   = q.rd_p;
endmodule

// File: rtl/i2c_target_framer.sv
module i2c_target_framer
    import i2cs_pkg::*;
#(
    parameter int ADDR_HI_W   = 5,
    parameter logic [ADDR_HI_W-1:0] ADDR_HI = 5'b10100,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    input  logic [7:0] rd_data_i,
    output logic       sda_oe_o,
    output logic       start_o,
    output logic       stop_o,
    output logic       sel_o,
    output logic       wr_valid_o,
    output logic [7:0] wr_data_o,
    output logic       rd_req_o
);
    localparam int NUM_LINES = 2;
    localparam int IDX_SCL   = 0;
    localparam int IDX_SDA   = 1;

    logic [NUM_LINES-1:0] line_raw;
    logic [NUM_LINES-1:0] line_clean;
    bus_evt_t             evt;

    assign line_raw[IDX_SCL] = scl_i;
    assign line_raw[IDX_SDA] = sda_i;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        i2cs_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filter (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(line_raw[g]),
            .line_o(line_clean[g])
        );
    end

    i2cs_cond_detect u_cond (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_f(line_clean[IDX_SCL]),
        .sda_f(line_clean[IDX_SDA]),
        .evt_o(evt)
    );

    i2cs_frame_fsm #(
        .ADDR_HI_W(ADDR_HI_W),
        .ADDR_HI  (ADDR_HI)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .sda_f     (line_clean[IDX_SDA]),
        .strap_i   (strap_i),
        .rd_data_i (rd_data_i),
        .sda_oe_o  (sda_oe_o),
        .start_o   (start_o),
        .stop_o    (stop_o),
        .sel_o     (sel_o),
        .wr_valid_o(wr_valid_o),
        .wr_data_o (wr_data_o),
        .rd_req_o  (rd_req_o)
    );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
    input logic clk,
    input logic rst_n,
    input logic sda_oe_o,
    input logic start_o,
    input logic stop_o,
    input logic sel_o,
    input logic wr_valid_o,
    input logic scl_fall_i
);
    // R10: drive level moves only after a falling SCL or a bus condition
    assert_oe_moves_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> ($past(scl_fall_i) || start_o || stop_o));

    // R7: an accepted stop leaves SDA released
    assert_release_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !sda_oe_o);

    // R9: a start or repeated start leaves SDA released
    assert_release_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !sda_oe_o);

    // R3: address match comes with the acknowledge driven low
    assert_ack_on_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o |-> sda_oe_o);

    // R4: a written byte comes with the acknowledge driven low
    assert_ack_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> sda_oe_o);

    // R1: start and stop are never reported together
    assert_cond_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));
endmodule

bind i2c_target_framer i2cs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe_o  (sda_oe_o),
    .start_o   (start_o),
    .stop_o    (stop_o),
    .sel_o     (sel_o),
    .wr_valid_o(wr_valid_o),
    .scl_fall_i(evt.scl_fall)
);

// File: tb/test_i2c_target_framer.sv
`timescale 1ns/1ps
module test_i2c_target_framer;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'd1;
    logic [7:0] rd_mem [4];
    int         rd_idx = 0;
    logic [7:0] rd_data;
    logic       sda_bus;

    logic       sda_oe_o, start_o, stop_o, sel_o, wr_valid_o, rd_req_o;
    logic [7:0] wr_data_o;

    int n_chk = 0, n_fail = 0, cycles = 0;
    int n_start = 0, n_stop = 0, n_sel = 0, n_rd = 0;
    logic [7:0] wr_log [$];
    logic [7:0] rd_got [$];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe_o;
    assign rd_data = rd_mem[rd_idx % 4];

    i2c_target_framer i_i2c_target_framer (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .strap_i(strap), .rd_data_i(rd_data), .sda_oe_o(sda_oe_o),
        .start_o(start_o), .stop_o(stop_o), .sel_o(sel_o),
        .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o), .rd_req_o(rd_req_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    bit raw_c [6], raw_d [6];
    bit f1c, f1d, f2c, f2d, m_arm;
    int m_mode;            // 0 idle 1 addr 2 addr-ack 3 write 4 write-ack 5 read 6 read-ack 7 ignore
    int m_bits;
    logic [7:0] m_byte;
    bit m_rw, m_nack;
    bit e_oe, e_start, e_stop, e_sel, e_wr, e_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 6; k++) begin raw_c[k] = 1; raw_d[k] = 1; end
            f1c = 1; f1d = 1; f2c = 1; f2d = 1; m_arm = 0;
            m_mode = 0; m_bits = 0; m_byte = 0; m_rw = 0; m_nack = 0;
            e_oe = 0; e_start = 0; e_stop = 0; e_sel = 0; e_wr = 0; e_rd = 0;
        end else begin
            bit nc, nd, rise, fall, st, sp;
            for (int k = 5; k > 0; k--) begin raw_c[k] = raw_c[k-1]; raw_d[k] = raw_d[k-1]; end
            raw_c[0] = scl_m; raw_d[0] = sda_bus;
            nc = (raw_c[3] == raw_c[4] && raw_c[4] == raw_c[5]) ? raw_c[5] : f1c;
            nd = (raw_d[3] == raw_d[4] && raw_d[4] == raw_d[5]) ? raw_d[5] : f1d;
            rise = f1c && !f2c;
            fall = !f1c && f2c;
            st = f1c && f2c && f2d && !f1d;
            sp = f1c && f2c && !f2d && f1d && !m_arm;
            if (st) m_arm = 1; else if (fall) m_arm = 0;
            e_start = 0; e_stop = 0; e_sel = 0; e_wr = 0; e_rd = 0;
            if (sp) begin
                m_mode = 0; e_oe = 0; e_stop = 1;
            end else if (st) begin
                m_mode = 1; m_bits = 0; e_oe = 0; e_start = 1;
            end else if ((m_mode == 1 || m_mode == 3) && rise && m_bits < 8) begin
                m_byte = {m_byte[6:0], f1d}; m_bits++;
            end else if (m_mode == 1 && fall && m_bits == 8) begin
                if (m_byte[7:1] == {5'b10100, strap}) begin
                    m_mode = 2; m_rw = m_byte[0]; e_oe = 1; e_sel = 1;
                end else begin
                    m_mode = 7; e_oe = 0;
                end
            end else if (m_mode == 3 && fall && m_bits == 8) begin
                m_mode = 4; e_oe = 1; e_wr = 1;
            end else if ((m_mode == 2 && !m_rw && fall) || (m_mode == 4 && fall)) begin
                m_mode = 3; m_bits = 0; e_oe = 0;
            end else if ((m_mode == 2 && m_rw && fall) || (m_mode == 6 && fall && !m_nack)) begin
                m_mode = 5; m_bits = 0; m_byte = rd_data; e_oe = !rd_data[7]; e_rd = 1;
            end else if (m_mode == 6 && fall && m_nack) begin
                m_mode = 7; e_oe = 0;
            end else if (m_mode == 6 && rise) begin
                m_nack = f1d;
            end else if (m_mode == 5 && fall) begin
                if (m_bits == 7) begin
                    m_mode = 6; e_oe = 0;
                end else begin
                    m_byte = m_byte << 1; e_oe = !m_byte[7]; m_bits++;
                end
            end
            f2c = f1c; f2d = f1d; f1c = nc; f1d = nd;
        end
    end

    // per-cycle comparison and event bookkeeping, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(sda_oe_o == e_oe,     "R10 sda_oe", sda_oe_o, e_oe);
            check(start_o == e_start,   "R1 start",   start_o, e_start);
            check(stop_o == e_stop,     "R7 stop",    stop_o, e_stop);
            check(sel_o == e_sel,       "R3 sel",     sel_o, e_sel);
            check(wr_valid_o == e_wr,   "R4 wr_valid", wr_valid_o, e_wr);
            check(rd_req_o == e_rd,     "R5 rd_req",  rd_req_o, e_rd);
            if (wr_valid_o && e_wr)
                check(wr_data_o == m_byte, "R4 wr_data", wr_data_o, m_byte);
            if (start_o) n_start++;
            if (stop_o)  n_stop++;
            if (sel_o)   n_sel++;
            if (wr_valid_o) wr_log.push_back(wr_data_o);
            if (rd_req_o) begin n_rd++; rd_idx++; end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    // ---------------- bus master tasks ----------------
    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic do_start();      // from idle: SCL and SDA high
        sda_m = 0; wq(); scl_m = 0; wq();
    endtask

    task automatic do_rstart();     // from SCL low
        sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
    endtask

    task automatic do_stop();       // from SCL low
        sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(2);
    endtask

    task automatic send_bit(input bit b);
        sda_m = b; wq(); scl_m = 1; wq(2); scl_m = 0; wq();
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1; wq(); scl_m = 1; wq(); b = sda_bus; wq(); scl_m = 0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        get_bit(ack);
    endtask

    task automatic read_byte(input bit mnack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            bit b;
            get_bit(b);
            v[i] = b;
        end
        send_bit(mnack);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        bit ack;
        logic [7:0] v;
        int s0, p0, l0, r0;
        rd_mem[0] = 8'hC3; rd_mem[1] = 8'h5A; rd_mem[2] = 8'h81; rd_mem[3] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2: reset state
        check(sda_oe_o == 0 && start_o == 0 && stop_o == 0 && sel_o == 0 &&
              wr_valid_o == 0 && rd_req_o == 0, "R2 reset outputs",
              {sda_oe_o, start_o, stop_o, sel_o, wr_valid_o, rd_req_o}, 0);
        wq(2);

        // Write to own address 0x51 (strap 1)
        do_start();
        send_byte(8'hA2, ack); check(ack == 0, "R3 address ack", ack, 0);
        send_byte(8'hA5, ack); check(ack == 0, "R4 data ack 1", ack, 0);
        send_byte(8'h3C, ack); check(ack == 0, "R4 data ack 2", ack, 0);
        do_stop(); wq(2);
        check(wr_log.size() == 2, "R4 byte count", wr_log.size(), 2);
        if (wr_log.size() == 2) begin
            check(wr_log[0] == 8'hA5, "R4 byte0", wr_log[0], 8'hA5);
            check(wr_log[1] == 8'h3C, "R4 byte1", wr_log[1], 8'h3C);
        end
        check(n_start == 1 && n_stop == 1, "R1 start/stop counts", n_start*16 + n_stop, 16 + 1);

        // Mismatched address 0x52 with strap 1
        l0 = wr_log.size(); s0 = n_sel;
        do_start();
        send_byte(8'hA4, ack); check(ack == 1, "R3 mismatch released", ack, 1);
        send_byte(8'h77, ack); check(ack == 1, "R3 ignored data released", ack, 1);
        do_stop(); wq(2);
        check(wr_log.size() == l0 && n_sel == s0, "R3 mismatch no select", n_sel - s0, 0);

        // Strap 2 selects address 0x52
        strap = 2'd2; wq();
        do_start();
        send_byte(8'hA4, ack); check(ack == 0, "R3 strap 2 address ack", ack, 0);
        send_byte(8'h07, ack); check(ack == 0, "R4 register byte ack", ack, 0);
        // R9: repeated start into a read
        s0 = n_start; p0 = n_stop;
        do_rstart();
        check(n_start == s0 + 1 && n_stop == p0, "R9 repeated start counted", n_start - s0, 1);
        send_byte(8'hA5, ack); check(ack == 0, "R9 read address ack", ack, 0);
        read_byte(0, v); rd_got.push_back(v);
        read_byte(0, v); rd_got.push_back(v);
        read_byte(1, v); rd_got.push_back(v);
        check(rd_got[0] == 8'hC3, "R5 read byte0", rd_got[0], 8'hC3);
        check(rd_got[1] == 8'h5A, "R5 read byte1", rd_got[1], 8'h5A);
        check(rd_got[2] == 8'h81, "R5 read byte2", rd_got[2], 8'h81);
        r0 = n_rd;
        check(r0 == 3, "R5 request count", r0, 3);
        // R6: after NACK the bus stays released
        read_byte(1, v);
        check(v == 8'hFF, "R6 released after nack", v, 8'hFF);
        check(n_rd == r0, "R6 no request after nack", n_rd, r0);
        do_stop(); wq(2);

        // R7: stop in the middle of a data byte
        l0 = wr_log.size(); p0 = n_stop;
        do_start();
        send_byte(8'hA4, ack);
        send_bit(1); send_bit(0); send_bit(1);
        do_stop(); wq(2);
        check(n_stop == p0 + 1, "R7 mid-byte stop seen", n_stop - p0, 1);
        check(wr_log.size() == l0, "R7 no partial byte", wr_log.size() - l0, 0);
        check(sda_oe_o == 0, "R7 released", sda_oe_o, 0);

        // R8: stop in the same SCL-high pulse as start is ignored
        p0 = n_stop; s0 = n_sel; l0 = wr_log.size();
        sda_m = 0; wq(); sda_m = 1; wq(); scl_m = 0; wq();
        check(n_stop == p0, "R8 stop rejected", n_stop - p0, 0);
        send_byte(8'hA4, ack); check(ack == 0, "R8 address still taken", ack, 0);
        check(n_sel == s0 + 1, "R8 select after rejected stop", n_sel - s0, 1);
        // R11: short SCL glitch inside a high phase
        for (int i = 7; i >= 0; i--) begin
            sda_m = (8'h96 >> i) & 1; wq(); scl_m = 1; wq();
            scl_m = 0; repeat (2) @(negedge clk); scl_m = 1; wq();
            scl_m = 0; wq();
        end
        get_bit(ack); check(ack == 0, "R11 byte ack after glitches", ack, 0);
        do_stop(); wq(2);
        check(wr_log.size() == l0 + 1, "R11 one byte only", wr_log.size() - l0, 1);
        if (wr_log.size() == l0 + 1)
            check(wr_log[l0] == 8'h96, "R11 byte intact", wr_log[l0], 8'h96);

        // R11: one-cycle SDA dip while bus idle makes no start
        s0 = n_start;
        sda_m = 0; @(negedge clk); sda_m = 1; wq(2);
        sda_m = 0; repeat (2) @(negedge clk); sda_m = 1; wq(2);
        check(n_start == s0, "R11 sda glitch ignored", n_start - s0, 0);

        wq(2);
        done = 1;
        finish_run();
    end
endmodule